// File: doc/BRIEF.md
# Range-Expanding State Table Loader

This block loads rows of a state transition table from a stream of compact host commands. A row holds one next-state entry for each of the 256 input symbols. Most rows contain only a few distinct next states, so the host does not send 256 single-entry writes for a row. It sends a short list of range commands instead. Each command names a state, an inclusive span of symbols and one next-state value. The block turns each command into a burst of table writes, one entry per clock, walking upward through the span. In a typical row this cuts host transfer volume by roughly tenfold.

States numbered below a hot-state limit are kept in on-chip tables. There are several identical copies of these tables, one for each group of matching engines, and every expanded write for such a state goes to all copies in the same cycle. All other states go to a single off-chip write port, which can stall the block with a ready signal. A command whose span is inverted is rejected: it raises a one-cycle error pulse and writes nothing. An end-of-update command raises a one-cycle done pulse. That pulse comes only after every write from earlier commands has been issued.

Top module: `rowfill_loader`

## Requirements
- R1: After reset, `cmd_ready` is 1, `done` and `err` are 0, no bit of `hot_we` is set and `cold_valid` is 0.
- R2: An accepted range command with `cmd_end`=0 produces exactly last−first+1 writes. The writes start in the cycle after acceptance, cover symbols first to last in ascending order, and all carry `cmd_next` as data. The write address is the state number concatenated above the 8-bit symbol (symbol in the low 8 bits).
- R3: For a state below `HOT_STATES`, each write sets every bit of `hot_we` in the same cycle. The on-chip address takes the low log2(`HOT_STATES`) bits of the state. `cold_valid` stays 0 during these writes.
- R4: For a state at or above `HOT_STATES`, writes go only to the off-chip port. A write completes only in a cycle where both `cold_valid` and `cold_ready` are 1. While `cold_ready` is 0, the address and data hold steady.
- R5: A range command whose last symbol is below its first symbol produces a one-cycle `err` pulse in the cycle after acceptance, and no write on either port.
- R6: A command whose first and last symbol are equal produces exactly one write.
- R7: `cmd_ready` is 0 from the cycle after a valid range command is accepted until that command's last write has completed, so no further command is taken during that time.
- R8: A command with `cmd_end`=1 produces a one-cycle `done` pulse in the cycle after acceptance. By then, all writes of earlier commands have been issued. `done` is 0 at all other times.
- R9: A span from symbol 0 to symbol 255 produces all 256 writes and stops without wrapping around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken when high together with cmd_valid |
| cmd_end | input | 1 | 1: end-of-update marker, 0: range command |
| cmd_state | input | STATE_W | State whose row is written |
| cmd_first | input | 8 | First symbol of the span |
| cmd_last | input | 8 | Last symbol of the span, inclusive |
| cmd_next | input | NEXT_W | Next-state value written for the span |
| hot_we | output | COPIES | Write enable, one bit per on-chip copy |
| hot_addr | output | log2(HOT_STATES)+8 | On-chip entry address {state, symbol} |
| hot_data | output | NEXT_W | On-chip write data |
| cold_valid | output | 1 | Off-chip write request |
| cold_ready | input | 1 | Off-chip port accepts the request |
| cold_addr | output | STATE_W+8 | Off-chip entry address {state, symbol} |
| cold_data | output | NEXT_W | Off-chip write data |
| done | output | 1 | One-cycle pulse after an end command |
| err | output | 1 | One-cycle pulse after a rejected command |

## Verification
The bench tests the boundary between the two tiers with states 255 and 256. A wrong comparison there would send a row to the wrong memory, and the scoreboard would see an unexpected port. Full-row and single-symbol spans catch counters that wrap past 255 or stop one entry early or late. An inverted span must raise the error and write nothing; a design that wraps the span instead would produce a flood of writes that no expected item matches. Stalls on the off-chip port, together with an end marker sent while a burst is still draining, expose a loader that drops or repeats entries under backpressure, or that signals done before the last entry is out.

// File: rtl/rowfill_loader.sv
module rowfill_loader #(
  parameter int STATE_W    = 16,
  parameter int NEXT_W     = 16,
  parameter int HOT_STATES = 256,
  parameter int COPIES     = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  output logic                  cmd_ready,
  input  logic                  cmd_end,
  input  logic [STATE_W-1:0]    cmd_state,
  input  logic [7:0]            cmd_first,
  input  logic [7:0]            cmd_last,
  input  logic [NEXT_W-1:0]     cmd_next,
  output logic [COPIES-1:0]     hot_we,
  output logic [$clog2(HOT_STATES)+7:0] hot_addr,
  output logic [NEXT_W-1:0]     hot_data,
  output logic                  cold_valid,
  input  logic                  cold_ready,
  output logic [STATE_W+7:0]    cold_addr,
  output logic [NEXT_W-1:0]     cold_data,
  output logic                  done,
  output logic                  err
);
  localparam int HOT_W = $clog2(HOT_STATES);

  logic               busy_q, cold_q, done_q, err_q;
  logic [STATE_W-1:0] state_q;
  logic [7:0]         sym_q, last_q;
  logic [NEXT_W-1:0]  next_q;

  wire accept  = cmd_valid && cmd_ready;
  wire is_hot  = cmd_state < STATE_W'(HOT_STATES);
  wire step    = busy_q && (!cold_q || cold_ready);
  wire at_last = sym_q == last_q;

  assign cmd_ready  = !busy_q;
  assign done       = done_q;
  assign err        = err_q;
  assign hot_addr   = {state_q[HOT_W-1:0], sym_q};
  assign hot_data   = next_q;
  assign cold_valid = busy_q && cold_q;
  assign cold_addr  = {state_q, sym_q};
  assign cold_data  = next_q;

  for (genvar i = 0; i < COPIES; i++) begin : g_copy
    assign hot_we[i] = busy_q && !cold_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cold_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      state_q <= '0;
      sym_q   <= '0;
      last_q  <= '0;
      next_q  <= '0;
    end else begin
      done_q <= accept && cmd_end;
      err_q  <= accept && !cmd_end && (cmd_last < cmd_first);
      if (accept && !cmd_end && !(cmd_last < cmd_first)) begin
        busy_q  <= 1'b1;
        cold_q  <= !is_hot;
        state_q <= cmd_state;
        sym_q   <= cmd_first;
        last_q  <= cmd_last;
        next_q  <= cmd_next;
      end else if (step) begin
        if (at_last) busy_q <= 1'b0;
        else         sym_q  <= sym_q + 8'd1;
      end
    end
  end

  p_all_copies_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|hot_we) |-> ((&hot_we) && !cold_valid));

  p_cold_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cold_valid && !cold_ready) |=> (cold_valid && $stable(cold_addr) && $stable(cold_data)));

  p_no_write_on_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!(|hot_we) && !cold_valid && !done));

  p_hot_ascend_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((|hot_we) && !at_last) |=> ((|hot_we) && hot_addr[7:0] == $past(hot_addr[7:0]) + 8'd1));

  p_busy_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|hot_we) || cold_valid) |-> !cmd_ready);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!(|hot_we) && !cold_valid && !err));
endmodule

// File: tb/rowfill_loader_tb.sv
`timescale 1ns/1ps
module rowfill_loader_tb;
  localparam int STATE_W = 16, NEXT_W = 16, HOT_STATES = 256, COPIES = 24;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic cmd_valid = 0, cmd_end = 0, cold_ready = 1;
  logic [STATE_W-1:0] cmd_state = 0;
  logic [7:0] cmd_first = 0, cmd_last = 0;
  logic [NEXT_W-1:0] cmd_next = 0;
  logic cmd_ready, cold_valid, done, err;
  logic [COPIES-1:0] hot_we;
  logic [15:0] hot_addr;
  logic [NEXT_W-1:0] hot_data, cold_data;
  logic [STATE_W+7:0] cold_addr;

  rowfill_loader #(.STATE_W(STATE_W), .NEXT_W(NEXT_W), .HOT_STATES(HOT_STATES), .COPIES(COPIES)) u_dut (
    .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_end, .cmd_state, .cmd_first, .cmd_last,
    .cmd_next, .hot_we, .hot_addr, .hot_data, .cold_valid, .cold_ready, .cold_addr,
    .cold_data, .done, .err);

  int checks = 0, fails = 0, writes = 0;
  logic [40:0] expq[$];
  bit stall = 0;
  int cyc = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 cold_ready <= stall ? (cyc % 3 != 0) : 1'b1;
  end

  always @(negedge clk) if (rst_n) begin
    logic [40:0] got, exp;
    if (|hot_we) begin
      check(&hot_we, "R3", "copies enabled", hot_we, {COPIES{1'b1}});
      check(!cold_valid, "R3", "cold port idle", cold_valid, 0);
      got = {1'b0, 8'd0, hot_addr, hot_data};
      writes++;
      if (expq.size() == 0) check(0, "R5", "unexpected hot write", got, 0);
      else begin exp = expq.pop_front(); check(got == exp, "R2", "hot write", got, exp); end
    end else if (cold_valid && cold_ready) begin
      got = {1'b1, cold_addr, cold_data};
      writes++;
      if (expq.size() == 0) check(0, "R5", "unexpected cold write", got, 0);
      else begin exp = expq.pop_front(); check(got == exp, "R4", "cold write", got, exp); end
    end
  end

  task automatic send(bit e, int st, int f, int l, int nx);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    if (!e && l >= f)
      for (int s = f; s <= l; s++)
        expq.push_back((st < HOT_STATES) ? {1'b0, 8'd0, st[7:0], s[7:0], nx[15:0]}
                                         : {1'b1, st[15:0], s[7:0], nx[15:0]});
    cmd_end = e; cmd_state = st[STATE_W-1:0]; cmd_first = f[7:0];
    cmd_last = l[7:0]; cmd_next = nx[NEXT_W-1:0]; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    check(0, "R1", "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(cmd_ready == 1, "R1", "ready after reset", cmd_ready, 1);
    check(hot_we == 0 && !cold_valid, "R1", "no write after reset", {hot_we, cold_valid}, 0);
    check(!done && !err, "R1", "status after reset", {done, err}, 0);

    send(0, 5, 10, 20, 16'h0077);
    check(!cmd_ready, "R7", "ready low during burst", cmd_ready, 0);
    drain();
    send(0, 200, 3, 3, 16'h1234);
    drain();
    check(writes == 12, "R6", "single-symbol write count", writes, 12);

    send(0, 255, 250, 255, 16'h00AA);
    drain();
    stall = 1;
    send(0, 256, 0, 15, 16'hBEEF);
    check(!cmd_ready, "R7", "ready low during cold burst", cmd_ready, 0);
    drain();
    send(0, 1000, 100, 140, 16'h0F0F);
    drain();
    stall = 0;
    check(writes == 75, "R4", "cold write count", writes, 75);

    send(0, 9, 9, 4, 16'h5555);
    check(err == 1, "R5", "err pulse", err, 1);
    repeat (4) @(negedge clk);
    check(err == 0, "R5", "err one cycle", err, 0);
    check(writes == 75, "R5", "no writes after reject", writes, 75);

    send(0, 7, 0, 255, 16'h2222);
    drain();
    check(writes == 331, "R9", "full row count", writes, 331);
    check(!done, "R8", "done low before end", done, 0);

    stall = 1;
    send(0, 4000, 0, 30, 16'h3333);
    send(1, 0, 0, 0, 0);
    check(done == 1, "R8", "done pulse", done, 1);
    check(expq.size() == 0, "R8", "all writes before done", expq.size(), 0);
    @(negedge clk);
    check(done == 0, "R8", "done one cycle", done, 0);
    stall = 0;
    check(writes == 362, "R2", "total writes", writes, 362);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule